// File: doc/BRIEF.md
# Two-Key Write Protection Guard

This block decides whether writes to a bank of timekeeping registers may proceed. Software opens the bank by writing two bytes, first 0xCA and then 0x53, to a dedicated key register. Any other byte, or the right bytes in the wrong order, closes the bank again at once. While the bank is closed, every write strobe aimed at a protected register is dropped, and a sticky flag records that a write was dropped.

The protection state is cleared only by the power-on reset. The system reset leaves the protection state as it is, so a running chip reset cannot open or close the bank. The system reset does clear the sticky discard flag. The block has one gated output strobe for each protected write port. Each gated strobe follows its input strobe in the same cycle when the bank is open.

Top module: `wp_guard`

## Requirements
- R1: After power-on reset (por_n low, asynchronous), wr_allow is 0, wr_err is 0 and every prot_wr_ok bit is 0.
- R2: A key write of 0xCA followed by a key write of 0x53 sets wr_allow to 1 in the cycle after the 0x53 write. wr_allow stays 0 after the 0xCA write alone.
- R3: After 0xCA has been accepted, a key write of any byte other than 0x53 (0xCA included) returns the block to locked. A later 0x53 then does not unlock it.
- R4: A key write of 0x53 that is not immediately preceded in key-write order by an accepted 0xCA leaves wr_allow at 0.
- R5: While unlocked, a key write of any byte other than 0xCA clears wr_allow in the next cycle. A key write of 0xCA also clears wr_allow, but it arms the sequence, so a following 0x53 unlocks the block again.
- R6: The system reset (sys_rst_n low, sampled on the clock) leaves the protection state unchanged, including a half-entered sequence, and clears wr_err.
- R7: prot_wr_ok[i] equals prot_wr[i] in the same cycle while wr_allow is 1, and is 0 while wr_allow is 0.
- R8: A cycle with any prot_wr bit high while wr_allow is 0 sets wr_err in the next cycle. wr_err then stays 1 until a system or power-on reset.
- R9: Cycles without a key write do not change the protection state. Idle cycles may separate the two key bytes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| sys_rst_n | input | 1 | System reset, active low, synchronous; clears only the discard flag |
| key_wr | input | 1 | Write strobe for the key register |
| key_data | input | 8 | Byte written to the key register |
| prot_wr | input | N_PORTS | Write strobes toward the protected registers |
| wr_allow | output | 1 | 1 while the protected bank is open |
| prot_wr_ok | output | N_PORTS | Write strobes after gating by the protection state |
| wr_err | output | 1 | Sticky flag: a protected write was discarded |

## Verification
A wrong protection state shows on wr_allow one cycle after the key write that caused it. It also shows in the same cycle on prot_wr_ok whenever a protected write is attempted. A state that is armed by mistake, or left armed when it should not be, stays hidden until the next key byte. For that reason the sequences check wr_allow after every single key write, and not only at the end of a sequence. Errors in the discard flag show on wr_err one cycle after the dropped write, so the checks also cover the flag staying set and being cleared by the system reset.

// File: rtl/wp_guard_pkg.sv
package wp_guard_pkg;

  localparam int KEY_W = 8;

  typedef enum logic [1:0] {
    ST_LOCKED = 2'd0,
    ST_ARMED  = 2'd1,
    ST_OPEN   = 2'd2
  } wp_state_e;

  // Next protection state after one key-register write.
  function automatic wp_state_e wp_step(
    input wp_state_e       cur,
    input logic [KEY_W-1:0] d,
    input logic [KEY_W-1:0] k_first,
    input logic [KEY_W-1:0] k_second
  );
    wp_state_e nxt;
    case (cur)
      ST_ARMED: nxt = (d == k_second) ? ST_OPEN  : ST_LOCKED;
      ST_OPEN:  nxt = (d == k_first)  ? ST_ARMED : ST_LOCKED;
      default:  nxt = (d == k_first)  ? ST_ARMED : ST_LOCKED;
    endcase
    return nxt;
  endfunction

endpackage

// File: rtl/wp_key_fsm.sv
module wp_key_fsm
  import wp_guard_pkg::*;
#(
  parameter logic [KEY_W-1:0] KEY_FIRST  = 8'hCA,
  parameter logic [KEY_W-1:0] KEY_SECOND = 8'h53
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             key_wr,
  input  logic [KEY_W-1:0] key_data,
  output wp_state_e        state_o,
  output logic             unlocked_o
);

  wp_state_e state_q;

  // Named events, brought out for the assertions.
  logic hit_first;
  logic hit_second;
  logic key_good;
  logic key_bad;

  assign hit_first  = key_wr && (key_data == KEY_FIRST);
  assign hit_second = key_wr && (key_data == KEY_SECOND);
  assign key_good   = (state_q == ST_ARMED) ? hit_second : hit_first;
  assign key_bad    = key_wr && !key_good;

  // Only power-on reset touches the protection state.
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      state_q <= ST_LOCKED;
    end else if (key_wr) begin
      state_q <= wp_step(state_q, key_data, KEY_FIRST, KEY_SECOND);
    end
  end

  assign state_o    = state_q;
  assign unlocked_o = (state_q == ST_OPEN);

  // R9: no key write, no state change
  a_r9_idle_hold: assert property (@(posedge clk) disable iff (!por_n)
    !key_wr |=> $stable(state_q));

  // R3 / R4 / R5: a byte that is out of sequence always locks
  a_r3_bad_byte_locks: assert property (@(posedge clk) disable iff (!por_n)
    key_bad |=> (state_q == ST_LOCKED));

  // R2: opening only follows the second key in the armed state
  a_r2_open_source: assert property (@(posedge clk) disable iff (!por_n)
    $rose(unlocked_o) |-> $past(hit_second && (state_q == ST_ARMED)));

  // R5: any key write while open leaves the open state
  a_r5_open_leaves: assert property (@(posedge clk) disable iff (!por_n)
    (key_wr && state_q == ST_OPEN) |=> (state_q != ST_OPEN));

endmodule

// File: rtl/wp_write_gate.sv
module wp_write_gate #(
  parameter int N_PORTS = 4
) (
  input  logic               clk,
  input  logic               por_n,
  input  logic               sys_rst_n,
  input  logic               allow,
  input  logic [N_PORTS-1:0] prot_wr,
  output logic [N_PORTS-1:0] prot_wr_ok,
  output logic               discard_o,
  output logic               wr_err
);

  logic [N_PORTS-1:0] blocked;

  for (genvar g = 0; g < N_PORTS; g++) begin : g_port
    assign prot_wr_ok[g] = prot_wr[g] & allow;
    assign blocked[g]    = prot_wr[g] & ~allow;
  end

  assign discard_o = |blocked;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      wr_err <= 1'b0;
    end else if (!sys_rst_n) begin
      wr_err <= 1'b0;
    end else if (discard_o) begin
      wr_err <= 1'b1;
    end
  end

  // R8: a dropped write raises the flag
  a_r8_discard_sets: assert property (@(posedge clk) disable iff (!por_n)
    (discard_o && sys_rst_n) |=> wr_err);

  // R8: the flag is sticky outside system reset
  a_r8_sticky: assert property (@(posedge clk) disable iff (!por_n)
    (wr_err && sys_rst_n) |=> wr_err);

  // R6: system reset clears the flag
  a_r6_sys_clears: assert property (@(posedge clk) disable iff (!por_n)
    !sys_rst_n |=> !wr_err);

  // R7: no write passes while closed
  a_r7_closed_gate: assert property (@(posedge clk) disable iff (!por_n)
    !allow |-> ($countones(prot_wr_ok) == 0));

endmodule

// File: rtl/wp_guard.sv
module wp_guard
  import wp_guard_pkg::*;
#(
  parameter int               N_PORTS    = 4,
  parameter logic [KEY_W-1:0] KEY_FIRST  = 8'hCA,
  parameter logic [KEY_W-1:0] KEY_SECOND = 8'h53
) (
  input  logic               clk,
  input  logic               por_n,
  input  logic               sys_rst_n,
  input  logic               key_wr,
  input  logic [KEY_W-1:0]   key_data,
  input  logic [N_PORTS-1:0] prot_wr,
  output logic               wr_allow,
  output logic [N_PORTS-1:0] prot_wr_ok,
  output logic               wr_err
);

  wp_state_e state;
  logic      unlocked;
  logic      discard;

  wp_key_fsm #(
    .KEY_FIRST  (KEY_FIRST),
    .KEY_SECOND (KEY_SECOND)
  ) u_fsm (
    .clk        (clk),
    .por_n      (por_n),
    .key_wr     (key_wr),
    .key_data   (key_data),
    .state_o    (state),
    .unlocked_o (unlocked)
  );

  wp_write_gate #(
    .N_PORTS (N_PORTS)
  ) u_gate (
    .clk        (clk),
    .por_n      (por_n),
    .sys_rst_n  (sys_rst_n),
    .allow      (unlocked),
    .prot_wr    (prot_wr),
    .prot_wr_ok (prot_wr_ok),
    .discard_o  (discard),
    .wr_err     (wr_err)
  );

  assign wr_allow = unlocked;

  // R6: system reset alone does not move the protection state
  a_r6_state_kept: assert property (@(posedge clk) disable iff (!por_n)
    (!sys_rst_n && !key_wr) |=> $stable(state));

  // R7: a discard never coincides with an open bank
  a_r7_discard_closed: assert property (@(posedge clk) disable iff (!por_n)
    discard |-> !wr_allow);

endmodule

// File: tb/tb_wp_guard.sv
module tb_wp_guard;

  localparam int N = 4;

  logic         clk = 1'b0;
  logic         por_n = 1'b0;
  logic         sys_rst_n = 1'b1;
  logic         key_wr = 1'b0;
  logic [7:0]   key_data = 8'h00;
  logic [N-1:0] prot_wr = '0;
  logic         wr_allow;
  logic [N-1:0] prot_wr_ok;
  logic         wr_err;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  wp_guard #(.N_PORTS(N)) dut (
    .clk        (clk),
    .por_n      (por_n),
    .sys_rst_n  (sys_rst_n),
    .key_wr     (key_wr),
    .key_data   (key_data),
    .prot_wr    (prot_wr),
    .wr_allow   (wr_allow),
    .prot_wr_ok (prot_wr_ok),
    .wr_err     (wr_err)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic key(input logic [7:0] d);
    @(negedge clk);
    key_wr   = 1'b1;
    key_data = d;
    @(negedge clk);
    key_wr   = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic lock_now();
    key(8'h00);
  endtask

  task automatic t_reset();
    por_n = 1'b0;
    idle(2);
    por_n = 1'b1;
    idle(1);
    chk("R1 allow after power-on", wr_allow, 0);
    chk("R1 err after power-on", wr_err, 0);
    chk("R1 gated strobes after power-on", prot_wr_ok, 0);
  endtask

  task automatic t_unlock();
    key(8'hCA);
    chk("R2 first key alone", wr_allow, 0);
    key(8'h53);
    chk("R2 full sequence opens", wr_allow, 1);
  endtask

  task automatic t_gate_open();
    @(negedge clk);
    prot_wr = 4'b1010;
    #1;
    chk("R7 strobes pass while open", prot_wr_ok, 4'b1010);
    @(negedge clk);
    prot_wr = '0;
    chk("R8 no flag for allowed write", wr_err, 0);
  endtask

  task automatic t_relock_open();
    key(8'h00);
    chk("R5 other byte relocks", wr_allow, 0);
    @(negedge clk);
    prot_wr = 4'b0001;
    #1;
    chk("R7 strobes blocked while locked", prot_wr_ok, 0);
    @(negedge clk);
    prot_wr = '0;
    chk("R8 flag set after discard", wr_err, 1);
    idle(5);
    chk("R8 flag sticky", wr_err, 1);
  endtask

  task automatic t_sysrst();
    sys_rst_n = 1'b0;
    idle(2);
    sys_rst_n = 1'b1;
    chk("R6 sys reset clears flag", wr_err, 0);
    chk("R6 sys reset keeps locked", wr_allow, 0);
    key(8'hCA);
    key(8'h53);
    sys_rst_n = 1'b0;
    idle(2);
    sys_rst_n = 1'b1;
    chk("R6 sys reset keeps open", wr_allow, 1);
    lock_now();
    key(8'hCA);
    sys_rst_n = 1'b0;
    idle(2);
    sys_rst_n = 1'b1;
    key(8'h53);
    chk("R6 armed survives sys reset", wr_allow, 1);
    lock_now();
  endtask

  task automatic t_bad_order();
    key(8'h53);
    chk("R4 lone second key", wr_allow, 0);
    key(8'h53);
    chk("R4 repeated second key", wr_allow, 0);
    key(8'hCA);
    key(8'hCA);
    key(8'h53);
    chk("R3 doubled first key locks", wr_allow, 0);
    key(8'hCA);
    key(8'h12);
    key(8'h53);
    chk("R3 wrong middle byte locks", wr_allow, 0);
  endtask

  task automatic t_reseq();
    key(8'hCA);
    key(8'h53);
    chk("R2 open before resequence", wr_allow, 1);
    key(8'hCA);
    chk("R5 first key drops allow", wr_allow, 0);
    key(8'h53);
    chk("R5 resequence reopens", wr_allow, 1);
    lock_now();
  endtask

  task automatic t_idle_gap();
    key(8'hCA);
    idle(5);
    key(8'h53);
    chk("R9 idle gap between keys", wr_allow, 1);
    idle(10);
    chk("R9 idle keeps open", wr_allow, 1);
  endtask

  task automatic t_por_again();
    por_n = 1'b0;
    idle(1);
    por_n = 1'b1;
    idle(1);
    chk("R1 power-on relocks", wr_allow, 0);
  endtask

  initial begin
    t_reset();
    t_unlock();
    t_gate_open();
    t_relock_open();
    t_sysrst();
    t_bad_order();
    t_reseq();
    t_idle_gap();
    t_por_again();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule